// File: doc/BRIEF.md
# Periodic-Tick Acknowledgement Tracker

This block follows one edge-triggered interrupt line that is reserved for a periodic clock tick. It records whether every processor that took the last tick has acknowledged it before the next tick goes out. For each of `NCPU` processors it keeps a pending bit and the vector that processor was given. It also keeps an outstanding-acknowledgement count. While that count is nonzero, `coal_o` is high and the interrupt controller drops the next assertion of the line and reports it as coalesced.

A delivery event loads the state. The delivery logic supplies a mask of the processors that accepted the tick and a signed count of acceptances. End-of-interrupt events retire pending entries. Restore events set or clear one processor's pending status, for example after processor state is reloaded.

The count can disagree with the bitmap, because the delivery logic reports the count separately from the mask. When a retirement would take the count below zero, the tracker rebuilds its whole state from a live per-processor pending vector.

Top module: `tick_ack_tracker`

## Requirements
- R1: After reset, `cnt_o` is 0, `coal_o` is 0 and `err_o` is 0, and every pending bit is clear, so a later end-of-interrupt has no effect on the count.
- R2: `coal_o` is 1 exactly when the registered outstanding count `cnt_o` is nonzero.
- R3: A delivery (`dlv_valid_i`) while the count is zero sets each pending bit from `dlv_mask_i` (bit i is processor i), records `dlv_vec_i` for every processor in the mask, and loads the count from the two's-complement `dlv_cnt_i`. A negative value loads 0, and a value above `NCPU` loads `NCPU`. The new count appears on the clock edge that samples the event.
- R4: A delivery while the count is nonzero changes no state, and `err_o` is 1 for the single cycle after it.
- R5: An end-of-interrupt (`eoi_valid_i`, binary processor index `eoi_cpu_i`, vector `eoi_vec_i`) decrements a nonzero count and clears that processor's bit only when the bit is set and the vector equals the recorded one. Any other end-of-interrupt has no effect.
- R6: A retirement that matches while the count is already zero is an underflow. On an underflow the bitmap becomes `pend_now_i`, `cur_vec_i` is recorded for every set bit, and the count becomes the number of ones in `pend_now_i`.
- R7: A restore (`rstr_valid_i`, index `rstr_cpu_i`, status `rstr_pend_i`) that sets a clear bit records `cur_vec_i` and increments the count, saturating at `NCPU`. A restore that clears a set bit retires it exactly as in R5, including the underflow rebuild of R6. A restore equal to the current bit has no effect.
- R8: Only one event is taken per cycle. A delivery blocks both other kinds in the same cycle, even when the delivery itself is ignored. An end-of-interrupt blocks a restore, even when it does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dlv_valid_i | input | 1 | Tick delivery event |
| dlv_mask_i | input | NCPU | Processors that accepted the tick |
| dlv_vec_i | input | VEC_W | Vector used for the delivery |
| dlv_cnt_i | input | CNT_W+1 | Signed acceptance count from the delivery logic |
| eoi_valid_i | input | 1 | End-of-interrupt event |
| eoi_cpu_i | input | ID_W | Processor issuing the end-of-interrupt |
| eoi_vec_i | input | VEC_W | Vector acknowledged |
| rstr_valid_i | input | 1 | Restore event |
| rstr_cpu_i | input | ID_W | Processor being restored |
| rstr_pend_i | input | 1 | New pending status for that processor |
| pend_now_i | input | NCPU | Live per-processor pending status, used for the rebuild |
| cur_vec_i | input | VEC_W | Vector currently programmed for the line |
| coal_o | output | 1 | Next assertion would be coalesced |
| cnt_o | output | CNT_W | Outstanding acknowledgement count |
| err_o | output | 1 | Delivery arrived while the count was nonzero |

## Verification
The underflow rebuild is the hardest case to reach, because normal traffic keeps the count equal to the number of set bits. The stimulus forces a mismatch on purpose. In one case it delivers to all processors with a negative acceptance count. In another it delivers with a zero count and then clears that processor through a restore. In both cases the next matching retirement finds a zero count. The rebuilt state is then checked by the count it loads from `pend_now_i`, and by a later end-of-interrupt that matches only the rebuilt vector. Same-cycle collisions of event kinds are driven directly to check the priority order.

// File: rtl/tat_pkg.sv
package tat_pkg;
   typedef enum logic [2:0] {
      ACT_IDLE,
      ACT_LOAD,
      ACT_REBUILD,
      ACT_RETIRE,
      ACT_ARM
   } tat_act_e;
endpackage

// File: rtl/tat_popcnt.sv
module tat_popcnt #(
   parameter int N     = 8,
   parameter int OUT_W = 4
) (
   input  logic [N-1:0]     vec_i,
   output logic [OUT_W-1:0] ones_o
);
   always_comb begin
      ones_o = '0;
      for (int i = 0; i < N; i++) begin
         ones_o = ones_o + OUT_W'(vec_i[i]);
      end
   end
endmodule

// File: rtl/tat_slot.sv
module tat_slot #(
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_d,
   input  logic             vec_we,
   input  logic [VEC_W-1:0] vec_d,
   output logic             bit_q,
   output logic [VEC_W-1:0] vec_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q <= 1'b0;
         vec_q <= '0;
      end else begin
         bit_q <= bit_d;
         if (vec_we) vec_q <= vec_d;
      end
   end
endmodule

// File: rtl/tick_ack_tracker.sv
module tick_ack_tracker
   import tat_pkg::*;
#(
   parameter int NCPU  = 8,
   parameter int VEC_W = 8,
   parameter int CNT_W = $clog2(NCPU + 1),
   parameter int ID_W  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    dlv_valid_i,
   input  logic [NCPU-1:0]         dlv_mask_i,
   input  logic [VEC_W-1:0]        dlv_vec_i,
   input  logic signed [CNT_W:0]   dlv_cnt_i,
   input  logic                    eoi_valid_i,
   input  logic [ID_W-1:0]         eoi_cpu_i,
   input  logic [VEC_W-1:0]        eoi_vec_i,
   input  logic                    rstr_valid_i,
   input  logic [ID_W-1:0]         rstr_cpu_i,
   input  logic                    rstr_pend_i,
   input  logic [NCPU-1:0]         pend_now_i,
   input  logic [VEC_W-1:0]        cur_vec_i,
   output logic                    coal_o,
   output logic [CNT_W-1:0]        cnt_o,
   output logic                    err_o
);
   localparam int DC_W = CNT_W + 1;
   localparam logic signed [DC_W-1:0] NCPU_S = DC_W'(NCPU);
   localparam logic [CNT_W-1:0]       NCPU_U = CNT_W'(NCPU);

   if (NCPU < 2 || NCPU > 64) begin : g_bad_ncpu
      $error("tick_ack_tracker: NCPU must lie in 2..64");
   end
   if (VEC_W < 1) begin : g_bad_vec
      $error("tick_ack_tracker: VEC_W must be positive");
   end
   if ((1 << CNT_W) <= NCPU) begin : g_bad_cnt
      $error("tick_ack_tracker: CNT_W too narrow for NCPU");
   end

   logic [NCPU-1:0]  bit_q, bit_d, vec_we;
   logic [VEC_W-1:0] vec_q [NCPU];
   logic [VEC_W-1:0] vec_src;
   logic [CNT_W-1:0] cnt_q, cnt_d, rebuild_cnt, load_cnt;
   logic             err_q;
   tat_act_e         act;

   logic             eoi_take, rs_take, eoi_hit, rs_old, rs_set, rs_clr;
   logic [ID_W-1:0]  ret_cpu;

   genvar gi;
   for (gi = 0; gi < NCPU; gi++) begin : g_slot
      tat_slot #(.VEC_W(VEC_W)) u_slot (
         .clk    (clk),
         .rst_n  (rst_n),
         .bit_d  (bit_d[gi]),
         .vec_we (vec_we[gi]),
         .vec_d  (vec_src),
         .bit_q  (bit_q[gi]),
         .vec_q  (vec_q[gi])
      );
   end

   tat_popcnt #(.N(NCPU), .OUT_W(CNT_W)) u_pop (
      .vec_i  (pend_now_i),
      .ones_o (rebuild_cnt)
   );

   // clamp the signed acceptance count into 0..NCPU
   always_comb begin
      if (dlv_cnt_i < 0)           load_cnt = '0;
      else if (dlv_cnt_i > NCPU_S) load_cnt = NCPU_U;
      else                         load_cnt = dlv_cnt_i[CNT_W-1:0];
   end

   // event selection: delivery > end-of-interrupt > restore
   always_comb begin
      eoi_take = !dlv_valid_i && eoi_valid_i;
      rs_take  = !dlv_valid_i && !eoi_valid_i && rstr_valid_i;
      eoi_hit  = 1'b0;
      rs_old   = 1'b0;
      if (int'(eoi_cpu_i) < NCPU)
         eoi_hit = eoi_take && bit_q[eoi_cpu_i] && (vec_q[eoi_cpu_i] == eoi_vec_i);
      if (int'(rstr_cpu_i) < NCPU)
         rs_old = bit_q[rstr_cpu_i];
      rs_set  = rs_take && rstr_pend_i && !rs_old;
      rs_clr  = rs_take && !rstr_pend_i && rs_old;
      ret_cpu = eoi_take ? eoi_cpu_i : rstr_cpu_i;

      if (dlv_valid_i && cnt_q == '0)       act = ACT_LOAD;
      else if (eoi_hit || rs_clr)           act = (cnt_q == '0) ? ACT_REBUILD : ACT_RETIRE;
      else if (rs_set)                      act = ACT_ARM;
      else                                  act = ACT_IDLE;
   end

   always_comb begin
      bit_d   = bit_q;
      vec_we  = '0;
      vec_src = cur_vec_i;
      cnt_d   = cnt_q;
      unique case (act)
         ACT_LOAD: begin
            bit_d   = dlv_mask_i;
            vec_we  = dlv_mask_i;
            vec_src = dlv_vec_i;
            cnt_d   = load_cnt;
         end
         ACT_REBUILD: begin
            bit_d  = pend_now_i;
            vec_we = pend_now_i;
            cnt_d  = rebuild_cnt;
         end
         ACT_RETIRE: begin
            bit_d[ret_cpu] = 1'b0;
            cnt_d          = cnt_q - 1'b1;
         end
         ACT_ARM: begin
            bit_d[rstr_cpu_i]  = 1'b1;
            vec_we[rstr_cpu_i] = 1'b1;
            if (cnt_q != NCPU_U) cnt_d = cnt_q + 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         err_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         err_q <= dlv_valid_i && (cnt_q != '0);
      end
   end

   assign cnt_o  = cnt_q;
   assign coal_o = |cnt_q;
   assign err_o  = err_q;
endmodule

// File: rtl/tat_chk.sv
module tat_chk #(
   parameter int NCPU  = 8,
   parameter int CNT_W = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  dlv_valid_i,
   input logic signed [CNT_W:0] dlv_cnt_i,
   input logic                  eoi_valid_i,
   input logic                  rstr_valid_i,
   input logic [CNT_W-1:0]      cnt_o,
   input logic                  err_o
);
   // R4
   busy_dlv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv_valid_i && cnt_o != '0) |=> (err_o && $stable(cnt_o)));

   // R4
   err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(dlv_valid_i));

   // R3
   dlv_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv_valid_i && cnt_o == '0 && dlv_cnt_i >= 0 && dlv_cnt_i <= NCPU)
      |=> (cnt_o == $past(dlv_cnt_i[CNT_W-1:0])));

   // R7
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_o) <= NCPU);

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dlv_valid_i && !eoi_valid_i && !rstr_valid_i) |=> $stable(cnt_o));
endmodule

bind tick_ack_tracker tat_chk #(.NCPU(NCPU), .CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .dlv_valid_i  (dlv_valid_i),
   .dlv_cnt_i    (dlv_cnt_i),
   .eoi_valid_i  (eoi_valid_i),
   .rstr_valid_i (rstr_valid_i),
   .cnt_o        (cnt_o),
   .err_o        (err_o)
);

// File: tb/sim_tick_ack_tracker.sv
module sim_tick_ack_tracker;
   localparam int NCPU = 8, VEC_W = 8, CNT_W = 4, ID_W = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic dlv_valid_i = 0, eoi_valid_i = 0, rstr_valid_i = 0, rstr_pend_i = 0;
   logic [NCPU-1:0] dlv_mask_i = '0, pend_now_i = '0;
   logic [VEC_W-1:0] dlv_vec_i = '0, eoi_vec_i = '0, cur_vec_i = 8'h40;
   logic signed [CNT_W:0] dlv_cnt_i = '0;
   logic [ID_W-1:0] eoi_cpu_i = '0, rstr_cpu_i = '0;
   logic coal_o, err_o;
   logic [CNT_W-1:0] cnt_o;
   int total = 0, bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   tick_ack_tracker u0 (.*);

   typedef struct packed {
      logic [1:0] kind;     // 0 idle, 1 deliver, 2 eoi, 3 restore
      logic [7:0] arg;      // mask, or cpu index; restore status in arg[7]
      logic [7:0] vec;
      logic signed [4:0] dc;
      logic [7:0] pend;
      logic [3:0] ecnt;
      logic       eerr;
   } tv_t;

   localparam int NV = 19;
   localparam tv_t TBL [NV] = '{
      '{2'd1, 8'h05, 8'h31,  5'sd2,  8'h00, 4'd2, 1'b0}, // R3
      '{2'd1, 8'h01, 8'h31,  5'sd1,  8'h00, 4'd2, 1'b1}, // R4
      '{2'd2, 8'h01, 8'h31,  5'sd0,  8'h00, 4'd2, 1'b0}, // R5 bit clear
      '{2'd2, 8'h00, 8'h32,  5'sd0,  8'h00, 4'd2, 1'b0}, // R5 vec mismatch
      '{2'd2, 8'h00, 8'h31,  5'sd0,  8'h00, 4'd1, 1'b0}, // R5 hit
      '{2'd2, 8'h00, 8'h31,  5'sd0,  8'h00, 4'd1, 1'b0}, // R5 repeat
      '{2'd2, 8'h02, 8'h31,  5'sd0,  8'h00, 4'd0, 1'b0}, // R5
      '{2'd1, 8'hFF, 8'h10, -5'sd3,  8'h00, 4'd0, 1'b0}, // R3 negative
      '{2'd2, 8'h03, 8'h10,  5'sd0,  8'h06, 4'd2, 1'b0}, // R6 rebuild
      '{2'd2, 8'h01, 8'h40,  5'sd0,  8'h00, 4'd1, 1'b0}, // R6 vec
      '{2'd2, 8'h02, 8'h10,  5'sd0,  8'h00, 4'd1, 1'b0}, // R6 old vec gone
      '{2'd2, 8'h02, 8'h40,  5'sd0,  8'h00, 4'd0, 1'b0}, // R6
      '{2'd3, 8'h85, 8'h00,  5'sd0,  8'h00, 4'd1, 1'b0}, // R7 set
      '{2'd3, 8'h85, 8'h00,  5'sd0,  8'h00, 4'd1, 1'b0}, // R7 same
      '{2'd3, 8'h05, 8'h00,  5'sd0,  8'h00, 4'd0, 1'b0}, // R7 clear
      '{2'd3, 8'h06, 8'h00,  5'sd0,  8'h00, 4'd0, 1'b0}, // R7 same clear
      '{2'd1, 8'h03, 8'h20,  5'sd12, 8'h00, 4'd8, 1'b0}, // R3 clamp high
      '{2'd2, 8'h00, 8'h20,  5'sd0,  8'h00, 4'd7, 1'b0}, // R5
      '{2'd0, 8'h00, 8'h00,  5'sd0,  8'h00, 4'd7, 1'b0}  // R2 idle
   };

   task automatic clear_in();
      dlv_valid_i = 0; eoi_valid_i = 0; rstr_valid_i = 0;
   endtask

   task automatic chk(string req, logic [3:0] ecnt, logic eerr);
      total += 3;
      if (cnt_o !== ecnt) begin
         bad++; $display("FAIL %s cnt actual=%0d expected=%0d", req, cnt_o, ecnt);
      end
      if (coal_o !== (ecnt != 0)) begin
         bad++; $display("FAIL %s/R2 coal actual=%0b expected=%0b", req, coal_o, ecnt != 0);
      end
      if (err_o !== eerr) begin
         bad++; $display("FAIL %s err actual=%0b expected=%0b", req, err_o, eerr);
      end
   endtask

   // apply inputs after the falling edge, check after the next falling edge
   task automatic step();
      @(negedge clk);
      clear_in();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset", 4'd0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int k = 0; k < NV; k++) begin
         pend_now_i = TBL[k].pend;
         case (TBL[k].kind)
            2'd1: begin dlv_valid_i = 1; dlv_mask_i = TBL[k].arg;
                        dlv_vec_i = TBL[k].vec; dlv_cnt_i = TBL[k].dc; end
            2'd2: begin eoi_valid_i = 1; eoi_cpu_i = TBL[k].arg[2:0];
                        eoi_vec_i = TBL[k].vec; end
            2'd3: begin rstr_valid_i = 1; rstr_cpu_i = TBL[k].arg[2:0];
                        rstr_pend_i = TBL[k].arg[7]; end
            default: ;
         endcase
         step();
         chk($sformatf("table row %0d", k), TBL[k].ecnt, TBL[k].eerr);
      end
      // R8: delivery blocks a matching eoi
      dlv_valid_i = 1; dlv_mask_i = 8'hFF; dlv_cnt_i = 5'sd1;
      eoi_valid_i = 1; eoi_cpu_i = 3'd1; eoi_vec_i = 8'h20;
      step(); chk("R8 dlv over eoi", 4'd7, 1'b1);
      eoi_valid_i = 1; eoi_cpu_i = 3'd1; eoi_vec_i = 8'h20;
      step(); chk("R8 bit kept", 4'd6, 1'b0);
      // R8: non-matching eoi still blocks restore
      eoi_valid_i = 1; eoi_cpu_i = 3'd4; eoi_vec_i = 8'h99;
      rstr_valid_i = 1; rstr_cpu_i = 3'd4; rstr_pend_i = 1;
      step(); chk("R8 eoi over restore", 4'd6, 1'b0);
      // R1: reset clears bitmap
      rst_n = 0; @(negedge clk); chk("R1 reset again", 4'd0, 1'b0);
      rst_n = 1; @(negedge clk);
      pend_now_i = 8'hFF; eoi_valid_i = 1; eoi_cpu_i = 3'd1; eoi_vec_i = 8'h20;
      step(); chk("R1 bitmap empty", 4'd0, 1'b0);
      // R7 clear with zero count -> R6 rebuild
      dlv_valid_i = 1; dlv_mask_i = 8'h10; dlv_vec_i = 8'h55; dlv_cnt_i = 5'sd0;
      step(); chk("R3 zero count", 4'd0, 1'b0);
      pend_now_i = 8'h81; rstr_valid_i = 1; rstr_cpu_i = 3'd4; rstr_pend_i = 0;
      step(); chk("R7 restore underflow", 4'd2, 1'b0);
      pend_now_i = 8'h00; eoi_valid_i = 1; eoi_cpu_i = 3'd7; eoi_vec_i = 8'h40;
      step(); chk("R6 rebuilt vector", 4'd1, 1'b0);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule